// File: doc/BRIEF.md
# Compare-Toggle Frequency Timer

This block is a programmable timer with a set of compare channels. A counter steps up or down between zero and a programmable period value. The step rate comes from a prescaler of the core clock. Each channel watches the counter. Whenever a counter step happens while the counter equals the channel's compare value, the channel flips its waveform output and raises its match flag. A channel whose compare value lies inside the period therefore produces a square wave at half the cycle rate.

Software drives the block through a single-cycle synchronous register port: a write strobe, an address and write data, plus combinational read data. The control word holds these fields:

- the global enable,
- the prescaler select,
- the waveform-mode field,
- the overflow interrupt enable.

Direction is changed through a separate set address and a separate clear address. Status flags are cleared by writing ones to them. Output polarity can be inverted per channel.

Top module: `cmptgl_timer`

## Requirements
- R1: After a synchronous reset, the following are all zero: the counter, all toggle states, all flags, the control word, the direction, the inversion mask, the period and every compare value. With the inversion mask at zero, wave_out is 0 and irq is 0.
- R2: While counting up (direction 0), a counter step at a count greater than or equal to the period loads zero and sets the overflow flag (STATUS bit 0). Any other step adds one.
- R3: While counting down (direction 1), a counter step at count zero loads the period value and sets the overflow flag. Any other step subtracts one.
- R4: With the waveform-mode field (CTRL bits 6:4) equal to 0, a counter step with the count equal to channel y's compare value (address 8+y) inverts that channel's toggle state. The toggle state changes on the same clock edge as the count.
- R5: Such a step also sets match flag y, which is STATUS bit y+1.
- R6: The prescaler select (CTRL bits 3:1) codes 0 to 7 give one counter step every 1, 2, 4, 8, 16, 64, 256 or 1024 enabled clocks. The first step comes that many clocks after the enable takes effect.
- R7: Writing bit 0 = 1 to address 2 selects down-counting. Writing bit 0 = 1 to address 1 selects up-counting. The direction reads back at CTRL bit 8.
- R8: wave_out[y] equals channel y's toggle state XOR inversion mask bit y (address 4).
- R9: irq is high exactly when the overflow flag and the overflow interrupt enable (CTRL bit 7) are both set.
- R10: Writing 1s to STATUS (address 3) clears the corresponding flags. A flag that is set by an event in the same cycle as the clear stays set.
- R11: With the enable (CTRL bit 0) at 0, the counter, the prescaler and the toggle states hold. With a nonzero waveform-mode field, the counter still steps, but no toggle occurs and no match flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address (0 CTRL, 1 DIRCLR, 2 DIRSET, 3 STATUS, 4 INVERT, 5 PERIOD, 6 COUNT, 8+y compare y) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| wave_out | output | N_CH | Per-channel waveform outputs |
| irq | output | 1 | Overflow interrupt request |

## Verification
A flag can be set by a counter event in the same cycle that software writes a one to clear it. The bench provokes this by writing STATUS on every clock for stretches of the run, so some clear writes land on the wrap or match step. It also makes a compare value equal to the period, so a toggle and an overflow fall in the same step. A behavioural model, updated on every clock, is compared against the outputs and the read data. Any disagreement in the flags or the waveform is reported against R5, R10, R2 or R4.

// File: rtl/cmptgl_pkg.sv
package cmptgl_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int PRES_W  = 10;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIRCLR = 4'd1;
    localparam logic [ADDR_W-1:0] A_DIRSET = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd3;
    localparam logic [ADDR_W-1:0] A_INV    = 4'd4;
    localparam logic [ADDR_W-1:0] A_PER    = 4'd5;
    localparam logic [ADDR_W-1:0] A_CNT    = 4'd6;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

    typedef enum logic [2:0] {
        WM_TOGGLE = 3'd0
    } wave_mode_e;

    typedef struct packed {
        logic       ovf_ie;
        logic [2:0] wave;
        logic [2:0] psel;
        logic       en;
    } ctrl_t;

    // terminal value of the prescale counter (ratio minus one)
    function automatic logic [PRES_W-1:0] pres_limit(input logic [2:0] sel);
        logic [PRES_W-1:0] r;
        case (sel)
            3'd0:    r = 10'd0;
            3'd1:    r = 10'd1;
            3'd2:    r = 10'd3;
            3'd3:    r = 10'd7;
            3'd4:    r = 10'd15;
            3'd5:    r = 10'd63;
            3'd6:    r = 10'd255;
            default: r = 10'd1023;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmptgl_prescaler.sv
module cmptgl_prescaler
    import cmptgl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] psel,
    output logic       tick
);
    logic [PRES_W-1:0] div_q;
    logic [PRES_W-1:0] limit;

    assign limit = pres_limit(psel);
    assign tick  = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // R6: after a tick only the divide-by-one setting may tick again at once
    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || psel == 3'd0));

    // R11: a stopped prescaler never ticks
    p_stopped_r11: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> !tick);

endmodule

// File: rtl/cmptgl_counter.sv
module cmptgl_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         down,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         wrap
);
    assign wrap = step && (down ? (count == '0) : (count >= period));

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step) begin
            if (wrap)
                count <= down ? period : '0;
            else if (down)
                count <= count - 1'b1;
            else
                count <= count + 1'b1;
        end
    end

    p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !down && count >= period) |=> count == '0);

    p_down_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (step && down && count == '0) |=> count == $past(period));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count));

endmodule

// File: rtl/cmptgl_channel.sv
module cmptgl_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         mode_ok,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic         inv,
    output logic         hit,
    output logic         pin
);
    logic tog_q;

    assign hit = step && mode_ok && (count == cmp);
    assign pin = tog_q ^ inv;

    always_ff @(posedge clk) begin
        if (rst)
            tog_q <= 1'b0;
        else if (hit)
            tog_q <= ~tog_q;
    end

    p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        hit |=> tog_q != $past(tog_q));

    p_no_toggle_r11: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(tog_q));

endmodule

// File: rtl/cmptgl_timer.sv
module cmptgl_timer
    import cmptgl_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [N_CH-1:0]   wave_out,
    output logic              irq
);
    localparam int FLAG_W = N_CH + 1;

    ctrl_t              ctrl_q;
    logic               dir_q;
    logic [N_CH-1:0]    inv_q;
    logic [DATA_W-1:0]  per_q;
    logic [DATA_W-1:0]  cmp_q [N_CH];
    logic [N_CH-1:0]    mflag_q;
    logic               oflag_q;

    logic               tick;
    logic               wrap;
    logic [DATA_W-1:0]  count;
    logic [N_CH-1:0]    hit_v;
    logic               mode_ok;
    logic [ADDR_W-1:0]  cidx;
    logic               in_cmp;

    assign mode_ok = (ctrl_q.wave == WM_TOGGLE);
    assign cidx    = addr - A_CMP0;
    assign in_cmp  = (addr >= A_CMP0) && (cidx < ADDR_W'(N_CH));

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dir_q  <= 1'b0;
            inv_q  <= '0;
            per_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:   ctrl_q <= ctrl_t'(wdata[7:0]);
                A_DIRCLR: if (wdata[0]) dir_q <= 1'b0;
                A_DIRSET: if (wdata[0]) dir_q <= 1'b1;
                A_INV:    inv_q  <= wdata[N_CH-1:0];
                A_PER:    per_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // status flags: write one to clear, a same-cycle event wins
    logic [FLAG_W-1:0] clr_v;
    assign clr_v = (wr_en && addr == A_STAT) ? wdata[FLAG_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            oflag_q <= 1'b0;
            mflag_q <= '0;
        end else begin
            oflag_q <= (oflag_q & ~clr_v[0]) | wrap;
            mflag_q <= (mflag_q & ~clr_v[FLAG_W-1:1]) | hit_v;
        end
    end

    cmptgl_prescaler u_pres (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.en),
        .psel (ctrl_q.psel),
        .tick (tick)
    );

    cmptgl_counter #(.W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (tick),
        .down   (dir_q),
        .period (per_q),
        .count  (count),
        .wrap   (wrap)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[g] <= '0;
            else if (wr_en && in_cmp && cidx == ADDR_W'(g))
                cmp_q[g] <= wdata;
        end

        cmptgl_channel #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .step    (tick),
            .mode_ok (mode_ok),
            .count   (count),
            .cmp     (cmp_q[g]),
            .inv     (inv_q[g]),
            .hit     (hit_v[g]),
            .pin     (wave_out[g])
        );

        p_match_flag_r5: assert property (@(posedge clk) disable iff (rst)
            hit_v[g] |=> mflag_q[g]);

        p_idle_mode_r11: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q.wave != WM_TOGGLE) |-> !hit_v[g]);
    end

    assign irq = oflag_q & ctrl_q.ovf_ie;

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = {23'd0, dir_q, ctrl_q};
            A_STAT: rdata = 32'({mflag_q, oflag_q});
            A_INV:  rdata = 32'(inv_q);
            A_PER:  rdata = per_q;
            A_CNT:  rdata = count;
            default: begin
                for (int i = 0; i < N_CH; i++)
                    if (in_cmp && cidx == ADDR_W'(i))
                        rdata = cmp_q[i];
            end
        endcase
    end

    p_ovf_set_r10: assert property (@(posedge clk) disable iff (rst)
        wrap |=> oflag_q);

    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (wrap && ctrl_q.ovf_ie && !(wr_en && addr == A_CTRL)) |=> irq);

    p_disabled_r11: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |=> $stable(count));

endmodule

// File: tb/cmptgl_timer_tb.sv
module cmptgl_timer_tb_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd6;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] wave_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmptgl_timer #(.N_CH(N)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wave_out(wave_out), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // behavioural model
    int          shf [8] = '{0, 1, 2, 3, 4, 6, 8, 10};
    bit          m_en, m_ie, m_dir;
    bit [2:0]    m_ps, m_wave;
    bit [N-1:0]  m_inv, m_tog, m_mf;
    bit          m_of;
    bit [31:0]   m_per, m_cnt;
    bit [31:0]   m_cmp [N];
    int          m_pres;

    function automatic bit [31:0] exp_rd(input bit [3:0] a);
        case (a)
            4'd0: return {23'd0, m_dir, m_ie, m_wave, m_ps, m_en};
            4'd3: return 32'({m_mf, m_of});
            4'd4: return 32'(m_inv);
            4'd5: return m_per;
            4'd6: return m_cnt;
            default: begin
                if (a >= 8 && a < 8 + N) return m_cmp[a - 8];
                return 32'd0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_ie = 0; m_dir = 0; m_ps = 0; m_wave = 0;
            m_inv = 0; m_tog = 0; m_mf = 0; m_of = 0; m_per = 0; m_cnt = 0;
            m_pres = 0;
            for (int i = 0; i < N; i++) m_cmp[i] = 0;
        end else begin
            bit tk, wr;
            bit [N-1:0] hits;
            int lim;
            lim = (1 << shf[m_ps]) - 1;
            tk = m_en && (m_pres >= lim);
            m_pres = (!m_en || tk) ? 0 : m_pres + 1;
            wr = tk && (m_dir ? (m_cnt == 0) : (m_cnt >= m_per));
            hits = '0;
            for (int i = 0; i < N; i++)
                hits[i] = tk && (m_wave == 0) && (m_cnt == m_cmp[i]);
            if (tk) begin
                if (wr) m_cnt = m_dir ? m_per : 32'd0;
                else if (m_dir) m_cnt = m_cnt - 1;
                else m_cnt = m_cnt + 1;
            end
            m_tog = m_tog ^ hits;
            if (wr_en && addr == 4'd3) begin
                m_of = m_of & ~wdata[0];
                m_mf = m_mf & ~wdata[N:1];
            end
            m_of = m_of | wr;
            m_mf = m_mf | hits;
            if (wr_en) begin
                case (addr)
                    4'd0: begin
                        m_en = wdata[0]; m_ps = wdata[3:1];
                        m_wave = wdata[6:4]; m_ie = wdata[7];
                    end
                    4'd1: if (wdata[0]) m_dir = 0;
                    4'd2: if (wdata[0]) m_dir = 1;
                    4'd4: m_inv = wdata[N-1:0];
                    4'd5: m_per = wdata;
                    default: if (addr >= 8 && addr < 8 + N) m_cmp[addr - 8] = wdata;
                endcase
            end
        end
        #2;
        if (!done) begin
            chk(wave_out == (m_tog ^ m_inv), "R4 R8 wave", wave_out, m_tog ^ m_inv);
            chk(irq == (m_of & m_ie), "R9 irq", irq, m_of & m_ie);
            chk(rdata == exp_rd(addr), "R2 R3 R5 R6 R7 R10 R11 read", rdata, exp_rd(addr));
        end
    end

    task automatic wr(input bit [3:0] a, input bit [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; addr = 4'd6;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look(input bit [3:0] a, input int n);
        @(negedge clk);
        addr = a;
        repeat (n) @(negedge clk);
        addr = 4'd6;
    endtask

    // hammer STATUS clears every clock so some land on set events (R10)
    task automatic clr_storm(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1; addr = 4'd3; wdata = 32'h1F;
        end
        @(negedge clk);
        wr_en = 0; addr = 4'd6;
    endtask

    function automatic bit [31:0] ctl(input bit en, input bit [2:0] ps,
                                      input bit [2:0] wv, input bit ie);
        return {24'd0, ie, wv, ps, en};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(wave_out == 0, "R1 wave reset", wave_out, 0);
        chk(irq == 0, "R1 irq reset", irq, 0);
        chk(rdata == 0, "R1 count reset", rdata, 0);
        look(4'd3, 2);
        look(4'd0, 2);

        wr(4'd5, 9);
        wr(4'd8, 3);
        wr(4'd9, 9);      // equals period: toggle and wrap together
        wr(4'd10, 0);
        wr(4'd11, 20);    // never reached
        wr(4'd4, 32'b0100);
        wr(4'd0, ctl(1, 0, 0, 1));
        idle(40);
        look(4'd3, 15);
        clr_storm(25);
        idle(20);
        wr(4'd3, 32'h1F);
        // R6 prescaler
        wr(4'd0, ctl(1, 2, 0, 1));
        idle(120);
        wr(4'd0, ctl(1, 5, 0, 0));
        idle(900);
        // R7 / R3 down counting
        wr(4'd2, 1);
        look(4'd0, 2);
        wr(4'd0, ctl(1, 0, 0, 1));
        idle(40);
        clr_storm(30);
        wr(4'd0, ctl(1, 1, 0, 1));
        idle(60);
        wr(4'd1, 1);
        wr(4'd2, 0);      // bit0 clear: no effect
        look(4'd0, 2);
        idle(30);
        // R11 nonzero wave mode, then disable
        wr(4'd3, 32'h1F);
        wr(4'd0, ctl(1, 0, 3'd2, 1));
        idle(50);
        look(4'd3, 3);
        wr(4'd0, ctl(0, 0, 0, 1));
        idle(40);
        // period change below count, max prescale
        wr(4'd5, 3);
        wr(4'd8, 1);
        wr(4'd0, ctl(1, 7, 0, 1));
        idle(5000);
        wr(4'd0, ctl(1, 0, 0, 1));
        idle(30);
        look(4'd8, 1); look(4'd12, 1); look(4'd7, 1);
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1;
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

endmodule